// File: doc/BRIEF.md
# Stereo Serial Sample Transmitter

This block sends one stereo pair of signed sample words per frame over a single serial data line. The bit clock and the frame clock come in as levels sampled by a faster system clock, so the block works the same whether these clocks are made locally or received from an external master. A format input selects between two framings. In left-aligned framing the left word goes out while the frame clock is high, with no delay. In I2S framing the left word goes out while the frame clock is low, one bit period late.

A one-cycle strobe delivers a new left/right pair at any time. The pair is held until the start of the next left half-frame and is then committed as a unit. A short-frame input cuts each word to its upper bits for 32-slot frames. A power-down input forces the line low and stops transmission until the frame clock next changes level.

Top module: `audio_ser_tx`

## Requirements
- R1: After reset `sdata_o` is 0. The first bit-clock falling edge only records the frame-clock level. Nothing but zeros goes out until the frame clock is seen to change at a later falling edge.
- R2: Words go out most significant bit first. `sdata_o` changes only in the system-clock cycle after a bit-clock falling edge (a cycle where `bclk_i` is 0 and was 1 in the previous cycle) or when power-down is active. It holds steady while the bit clock is high.
- R3: With `fmt_i2s_i`=0, the left word is sent in the half-frame where `lrck_i`=1. Bit 23 is driven at the falling edge where the new frame-clock level is first seen (slot 0). Bit 23-k follows in slot k.
- R4: With `fmt_i2s_i`=1, the left word is sent in the half-frame where `lrck_i`=0. Slot 0 is driven 0, and bit 23-k is driven in slot k+1.
- R5: Without the short-frame input, 24 bits are sent per half-frame. Every slot after the last data bit is driven 0 until the next frame-clock change, even in half-frames longer than 32 slots.
- R6: With `short_frame_i`=1, only bits 23 down to 8 are sent (16 slots of data), with the same slot offsets as in R3 and R4.
- R7: A strobe on `smp_valid_i` captures both words. Both take effect only at the start of the next left half-frame. A strobe that arrives during a left half-frame does not change the right word of that same frame.
- R8: A strobe in the same cycle as the falling edge that starts a left half-frame supplies the words for that frame, including slot 0.
- R9: While `pwr_dn_i`=1, `sdata_o` is 0 from the next cycle on, and no pair is committed. After release, zeros continue until the frame clock is next seen to change.
- R10: A frame-clock change restarts the slot count even when the previous half-frame was too short to hold all its bits. For example, I2S framing with 24-slot halves drops bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn_i | input | 1 | Power-down: output held low, transmission stopped |
| bclk_i | input | 1 | Bit clock level, synchronous to `clk` |
| lrck_i | input | 1 | Frame clock level, synchronous to `clk` |
| fmt_i2s_i | input | 1 | 0: left-aligned framing, 1: I2S framing |
| short_frame_i | input | 1 | 1: send upper 16 bits per word |
| smp_valid_i | input | 1 | One-cycle strobe for a new sample pair |
| smp_left_i | input | 24 | Left sample word, two's complement |
| smp_right_i | input | 24 | Right sample word, two's complement |
| sdata_o | output | 1 | Serial data line |

## Verification
Two events can land in the same cycle: the commit of a pair at the start of a left half-frame and the arrival of a new strobe. The bench provokes this by raising `smp_valid_i` in exactly the cycle where the bit clock falls with the frame clock at its new left level. It expects the fresh words, not the older pending pair, starting at slot 0. A second case places the strobe inside a left half-frame and expects the following right half to still carry the older right word. Power-down asserted and released in the middle of a half-frame is judged the same way, slot by slot against a bench model.

// File: rtl/audio_ser_tx_pkg.sv
// Package: shared types for the serial sample transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package audio_ser_tx_pkg;

    // Framing choice, encoded as the format input level.
    typedef enum logic {
        FMT_LEFT_ALIGNED = 1'b0,
        FMT_I2S          = 1'b1
    } ser_fmt_e;

endpackage

// File: rtl/ast_edge_det.sv
// Module: ast_edge_det
// Detects bit-clock falling edges and frame-clock level changes at them.
// Assumes bclk_i and lrck_i are synchronous to clk and each level lasts
// at least one clk cycle. The first falling edge after reset only records
// the frame-clock level (no frame edge is reported for it).
module ast_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrck_i,
    output logic bit_fall_o,
    output logic frame_edge_o
);

    logic bclk_d;
    logic lr_prev;
    logic primed;

    assign bit_fall_o   = bclk_d & ~bclk_i;
    assign frame_edge_o = bit_fall_o & primed & (lrck_i != lr_prev);

    // Track the previous bit-clock level and the frame level seen at each fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d  <= 1'b0;
            lr_prev <= 1'b0;
            primed  <= 1'b0;
        end else begin
            bclk_d <= bclk_i;
            if (bit_fall_o) begin
                lr_prev <= lrck_i;
                primed  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ast_slot_ctr.sv
// Module: ast_slot_ctr
// Counts bit slots inside a half-frame. A frame edge makes the current
// slot 0. The count saturates at MAX_SLOTS, which the top treats as
// "no data". Power-down parks the count at MAX_SLOTS.
// Assumes MAX_SLOTS exceeds the longest data field plus one.
module ast_slot_ctr #(
    parameter int MAX_SLOTS = 63,
    parameter int CNT_W     = $clog2(MAX_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             restart_i,
    input  logic             hold_off_i,
    output logic [CNT_W-1:0] slot_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] PARK = CNT_W'(MAX_SLOTS);

    logic [CNT_W-1:0] cnt_q;

    assign slot_o = restart_i ? '0 : cnt_q;
    assign cnt_o  = cnt_q;

    // Advance the slot index on each bit-clock fall, saturating at PARK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= PARK;
        end else if (hold_off_i) begin
            cnt_q <= PARK;
        end else if (step_i) begin
            cnt_q <= (slot_o == PARK) ? PARK : slot_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ast_pair_hold.sv
// Module: ast_pair_hold
// Two-stage store for a stereo pair: a pending stage written by the
// strobe and a committed stage loaded at the start of a left half-frame.
// A strobe in the commit cycle bypasses straight into the committed stage.
// Assumes load_i is a single-cycle pulse.
module ast_pair_hold #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [W-1:0] left_i,
    input  logic [W-1:0] right_i,
    input  logic         load_i,
    output logic [W-1:0] eff_l_o,
    output logic [W-1:0] eff_r_o,
    output logic [W-1:0] hold_l_o,
    output logic [W-1:0] hold_r_o
);

    logic [W-1:0] pend_l, pend_r;
    logic [W-1:0] src_l, src_r;

    assign src_l   = valid_i ? left_i  : pend_l;
    assign src_r   = valid_i ? right_i : pend_r;
    assign eff_l_o = load_i ? src_l : hold_l_o;
    assign eff_r_o = load_i ? src_r : hold_r_o;

    // Capture every strobed pair into the pending stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_l <= '0;
            pend_r <= '0;
        end else if (valid_i) begin
            pend_l <= left_i;
            pend_r <= right_i;
        end
    end

    // Commit both words together when a left half-frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l_o <= '0;
            hold_r_o <= '0;
        end else if (load_i) begin
            hold_l_o <= src_l;
            hold_r_o <= src_r;
        end
    end

endmodule

// File: rtl/audio_ser_tx.sv
// Module: audio_ser_tx (top)
// Serializes a committed stereo pair MSB first onto sdata_o, one bit per
// bit-clock falling edge, in left-aligned or I2S framing. Words may be cut
// to their upper SHORT_W bits. Assumes bit and frame clocks are sampled
// levels synchronous to clk and the frame clock changes with the bit-clock fall.
module audio_ser_tx #(
    parameter int SMP_W     = 24,
    parameter int SHORT_W   = 16,
    parameter int MAX_SLOTS = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn_i,
    input  logic             bclk_i,
    input  logic             lrck_i,
    input  logic             fmt_i2s_i,
    input  logic             short_frame_i,
    input  logic             smp_valid_i,
    input  logic [SMP_W-1:0] smp_left_i,
    input  logic [SMP_W-1:0] smp_right_i,
    output logic             sdata_o
);

    import audio_ser_tx_pkg::*;

    localparam int CNT_W = $clog2(MAX_SLOTS + 1);
    localparam int IDX_W = $clog2(SMP_W);
    localparam logic [CNT_W-1:0] FULL_N  = CNT_W'(SMP_W);
    localparam logic [CNT_W-1:0] SHORT_N = CNT_W'(SHORT_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(SMP_W - 1);

    ser_fmt_e         fmt;
    logic             bit_fall;
    logic             frame_edge;
    logic             is_left;
    logic             pair_load;
    logic [CNT_W-1:0] slot;
    logic [CNT_W-1:0] slot_cnt;
    logic [CNT_W-1:0] data_n;
    logic [CNT_W-1:0] didx;
    logic             has_bit;
    logic             tx_bit;
    logic [SMP_W-1:0] eff_l, eff_r, hold_l, hold_r;
    logic [SMP_W-1:0] word;

    assign fmt = ser_fmt_e'(fmt_i2s_i);

    ast_edge_det u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_i       (bclk_i),
        .lrck_i       (lrck_i),
        .bit_fall_o   (bit_fall),
        .frame_edge_o (frame_edge)
    );

    ast_slot_ctr #(
        .MAX_SLOTS (MAX_SLOTS),
        .CNT_W     (CNT_W)
    ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (bit_fall),
        .restart_i  (frame_edge),
        .hold_off_i (pwr_dn_i),
        .slot_o     (slot),
        .cnt_o      (slot_cnt)
    );

    // Left half: frame clock high in left-aligned, low in I2S framing.
    assign is_left   = lrck_i ^ (fmt == FMT_I2S);
    assign pair_load = frame_edge & is_left & ~pwr_dn_i;

    ast_pair_hold #(
        .W (SMP_W)
    ) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (smp_valid_i),
        .left_i   (smp_left_i),
        .right_i  (smp_right_i),
        .load_i   (pair_load),
        .eff_l_o  (eff_l),
        .eff_r_o  (eff_r),
        .hold_l_o (hold_l),
        .hold_r_o (hold_r)
    );

    // Map the slot index to a data bit of the current channel's word.
    always_comb begin
        word   = is_left ? eff_l : eff_r;
        data_n = short_frame_i ? SHORT_N : FULL_N;
        if (fmt == FMT_I2S) begin
            has_bit = (slot != '0) && (slot <= data_n);
            didx    = slot - CNT_W'(1);
        end else begin
            has_bit = (slot < data_n);
            didx    = slot;
        end
        tx_bit = has_bit ? word[TOP_IDX - didx[IDX_W-1:0]] : 1'b0;
    end

    // Drive the line on bit-clock falls; force low in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata_o <= 1'b0;
        end else if (pwr_dn_i) begin
            sdata_o <= 1'b0;
        end else if (bit_fall) begin
            sdata_o <= tx_bit;
        end
    end

endmodule

// File: rtl/audio_ser_tx_chk.sv
// Module: audio_ser_tx_chk
// Property checker for audio_ser_tx, attached by the bind below.
// Assumes the internal names of the top module listed in the bind.
module audio_ser_tx_chk #(
    parameter int SMP_W     = 24,
    parameter int MAX_SLOTS = 63,
    parameter int CNT_W     = $clog2(MAX_SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_dn_i,
    input logic             fmt_i2s_i,
    input logic             sdata_o,
    input logic             bit_fall,
    input logic             frame_edge,
    input logic             pair_load,
    input logic [CNT_W-1:0] slot_cnt,
    input logic [SMP_W-1:0] hold_l,
    input logic [SMP_W-1:0] hold_r
);

    localparam logic [CNT_W-1:0] PARK = CNT_W'(MAX_SLOTS);

    // R9
    pd_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_i |=> !sdata_o);

    // R9
    pd_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_i |=> (slot_cnt == PARK));

    // R2
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_fall && !pwr_dn_i) |=> $stable(sdata_o));

    // R4
    i2s_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_fall && frame_edge && fmt_i2s_i && !pwr_dn_i) |=> !sdata_o);

    // R7
    pair_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_load |=> ($stable(hold_l) && $stable(hold_r)));

    // R5
    slot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_fall && !frame_edge && (slot_cnt == PARK)) |=> (slot_cnt == PARK));

endmodule

bind audio_ser_tx audio_ser_tx_chk #(
    .SMP_W     (SMP_W),
    .MAX_SLOTS (MAX_SLOTS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn_i   (pwr_dn_i),
    .fmt_i2s_i  (fmt_i2s_i),
    .sdata_o    (sdata_o),
    .bit_fall   (bit_fall),
    .frame_edge (frame_edge),
    .pair_load  (pair_load),
    .slot_cnt   (slot_cnt),
    .hold_l     (hold_l),
    .hold_r     (hold_r)
);

// File: tb/audio_ser_tx_tb_top.sv
`timescale 1ns/1ps
// Bench: drives bit and frame clocks from tasks, models the expected
// serial stream per half-frame and compares slot by slot.
module audio_ser_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        bclk = 1'b1;
    logic        lrck = 1'b0;
    logic        fmt = 1'b0;
    logic        shrt = 1'b0;
    logic        valid = 1'b0;
    logic [23:0] left_w = '0;
    logic [23:0] right_w = '0;
    logic        sdata;

    int checks = 0;
    int errors = 0;

    // Model state: pending and committed pairs.
    logic [23:0] pend_l = '0, pend_r = '0, cur_l = '0, cur_r = '0;

    always #2.5 clk = ~clk;

    audio_ser_tx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_dn_i      (pwr_dn),
        .bclk_i        (bclk),
        .lrck_i        (lrck),
        .fmt_i2s_i     (fmt),
        .short_frame_i (shrt),
        .smp_valid_i   (valid),
        .smp_left_i    (left_w),
        .smp_right_i   (right_w),
        .sdata_o       (sdata)
    );

    function automatic logic [63:0] exp_half(logic [23:0] w, bit i2s, bit cut, int n);
        logic [63:0] e = '0;
        int width = cut ? 16 : 24;
        for (int s = 0; s < n; s++) begin
            int d = i2s ? s - 1 : s;
            if (d >= 0 && d < width) e[s] = w[23 - d];
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One half-frame of n slots at frame level lr. vslot: strobe slot (-1 none);
    // pd_set / pd_rel: slots where power-down is raised / released (-1 none).
    task automatic run_half(input logic lr, input int n, input int vslot, input int pd_set,
                            input int pd_rel, input bit chk, input bit force_zero, input string tag);
        bit          is_left = lr ^ fmt;
        bit          pd0 = pwr_dn;
        bit          unstable = 1'b0;
        logic [23:0] nl = 24'($urandom);
        logic [23:0] nr = 24'($urandom);
        logic [63:0] rx = '0;
        logic [63:0] ex;
        if (is_left) begin
            if (vslot == 0) begin pend_l = nl; pend_r = nr; end
            if (!pd0) begin cur_l = pend_l; cur_r = pend_r; end
            if (vslot > 0) begin pend_l = nl; pend_r = nr; end
        end else if (vslot >= 0) begin
            pend_l = nl; pend_r = nr;
        end
        ex = exp_half(is_left ? cur_l : cur_r, fmt, shrt, n);
        if (pd0 || force_zero) ex = '0;
        if (pd_set >= 0)
            for (int s = pd_set; s < 64; s++) ex[s] = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bclk = 1'b0;
            if (i == 0) lrck = lr;
            if (i == vslot) begin valid = 1'b1; left_w = nl; right_w = nr; end
            if (i == pd_set) pwr_dn = 1'b1;
            if (i == pd_rel) pwr_dn = 1'b0;
            @(negedge clk);
            valid = 1'b0;
            @(negedge clk);
            bclk = 1'b1;
            rx[i] = sdata;
            @(negedge clk);
            if (sdata !== rx[i]) unstable = 1'b1;
        end
        if (chk) begin
            check(rx === ex, tag, rx, ex);
            check(!unstable, "R2 line moved while bit clock high", {63'd0, unstable}, 64'd0);
        end
    endtask

    task automatic run_frame(input int n, input string tag);
        logic left_lr = ~fmt;
        run_half(left_lr, n, -1, -1, -1, 1'b1, 1'b0, tag);
        run_half(~left_lr, n, 2 + int'($urandom % 10), -1, -1, 1'b1, 1'b0, tag);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: line low after reset
        check(sdata === 1'b0, "R1 reset level", {63'd0, sdata}, 64'd0);
        // R1: first fall only primes; no data without a seen frame change
        run_half(1'b0, 32, 5, -1, -1, 1'b1, 1'b1, "R1 priming half");

        // R3 / R5 / R2: left-aligned, 32-slot halves
        for (int f = 0; f < 5; f++) run_frame(32, "R3 left-aligned 64-slot frame");
        // R5: 24-slot halves hold full words exactly
        for (int f = 0; f < 3; f++) run_frame(24, "R5 left-aligned 48-slot frame");
        // R5: long halves, trailing slots low
        run_frame(40, "R5 long half-frame");

        // R4: I2S framing
        fmt = 1'b1;
        run_half(1'b1, 32, -1, -1, -1, 1'b0, 1'b0, "warmup");
        for (int f = 0; f < 5; f++) run_frame(32, "R4 I2S 64-slot frame");
        // R10: 24-slot I2S halves lose bit 0
        for (int f = 0; f < 3; f++) run_frame(24, "R10 I2S short half restart");

        // R6: 16-bit words
        shrt = 1'b1;
        for (int f = 0; f < 3; f++) run_frame(16, "R6 I2S 32-slot frame");
        fmt = 1'b0;
        run_half(1'b0, 16, -1, -1, -1, 1'b0, 1'b0, "warmup");
        for (int f = 0; f < 3; f++) run_frame(16, "R6 left-aligned 32-slot frame");
        run_frame(32, "R6 cut words in 64-slot frame");
        shrt = 1'b0;

        // R8: strobe in the commit cycle
        run_half(1'b1, 32, 0, -1, -1, 1'b1, 1'b0, "R8 strobe at left start");
        run_half(1'b0, 32, -1, -1, -1, 1'b1, 1'b0, "R8 right word of same pair");
        // R7: strobe during a left half leaves the right half unchanged
        run_half(1'b1, 32, 10, -1, -1, 1'b1, 1'b0, "R7 strobe mid left half");
        run_half(1'b0, 32, -1, -1, -1, 1'b1, 1'b0, "R7 right half keeps old pair");
        run_frame(32, "R7 next frame takes new pair");

        // R9: power-down mid-half, full frame down, release mid-half
        run_half(1'b1, 32, -1, 8, -1, 1'b1, 1'b0, "R9 power-down mid half");
        run_half(1'b0, 32, -1, -1, -1, 1'b1, 1'b0, "R9 held low in power-down");
        run_half(1'b1, 32, 3, -1, -1, 1'b1, 1'b0, "R9 no commit in power-down");
        run_half(1'b0, 32, -1, -1, 6, 1'b1, 1'b0, "R9 release mid half stays low");
        run_frame(32, "R9 resumes after frame change");

        finish_run();
    end

endmodule